// File: doc/BRIEF.md
# Programmable SPI Byte Sequencer

This block is a half-duplex SPI master whose transfers are steered by a small byte-coded program held in one 64-bit program register. Each of the eight bytes is one opcode. Slot 0 is the top byte, and execution walks toward the bottom byte. An opcode can drive a chip select, clock a number of bytes out of a 64-bit transmit word, clock a number of bytes into a 64-bit receive word, move the receive word into the transmit word, branch back to an earlier slot while a loop counter lasts, or stop.

Host software talks to the block through a flat register port of 64-bit words. It loads a loop configuration and a clock configuration, then writes the program, which starts execution at slot 0. It then feeds transmit words and drains receive words one at a time, using the full flags in the status word as the handshake. Because of the counted branch, a three- or four-opcode program can move far more bytes than one data word holds. The SPI pins run in mode 0: SCK idles low, MOSI changes on the falling edge and MISO is sampled on the rising edge.

Top module: `spi_byte_sequencer`

## Requirements
- R1: After reset the status word (register 8) reads exactly bit 48 set (engine idle), every chip select is high, SCK is low and the receive word (register 6) reads zero.
- R2: Opcode 0x1N with N from 1 to NUM_CS drives chip select N-1 low and all others high. N = 0, or any N above NUM_CS, drives every chip select high.
- R3: Opcode 0x3N (N = 1..8) clocks out the N most significant bytes of the transmit word (register 5), most significant byte first and each byte MSB first. Writing register 5 sets status bit 59. The engine waits while bit 59 is clear and clears it when it takes the word.
- R4: Opcode 0x4N (N = 1..8) clocks in N bytes and places them in the low N bytes of the receive word, with the first byte received as the most significant of those N bytes and the upper bytes zero. It then sets status bit 59+4 = 63. Reading register 6 clears bit 63.
- R5: A shift-in opcode waits without clocking SCK while status bit 63 is set. It proceeds once the host reads register 6.
- R6: Opcode 0xEN branches to slot N (N = 0..7) while the loop counter is non-zero, decrementing the counter each time it branches. The counter is loaded from bits 39:32 of register 1 when the program is written, so the branched body runs L+1 times in total for a count of L.
- R7: When bit 10 of register 1 is set, the first shift-in of a program does not start until one transmit word has been written. That word is consumed as a dummy (bit 59 clears), and no SCK edge occurs before that write.
- R8: Opcode 0xC0 waits until the receive word is full and the transmit word is empty. It then copies the receive word into the transmit word, setting bit 59 and clearing bit 63.
- R9: Opcode 0x00 returns the engine to idle (bit 48) and leaves the chip selects as they are. Opcodes with no defined meaning are skipped. After slot 7 the engine goes idle.
- R10: SCK is low whenever no byte is being shifted. While shifting, each high phase and each low phase lasts D+1 clock cycles, where D is bits 63:52 of register 3.
- R11: Writing register 5 while bit 59 is set drops the data and sets bit 58. Reading register 6 while bit 63 is clear sets bit 61. Any write to register 8 clears bits 58 and 61 and leaves the full flags unchanged. Bits 62 and 57 read zero.
- R12: A write to register 3 with bits 36 and 38 set, followed directly by a register 3 write with bits 37 and 39 set, aborts the engine. The status word then reads idle only, and every chip select goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (enables read side effects) |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_idx, combinational |
| spi_sck | output | 1 | SPI serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The bench sweeps every shift length from one to eight bytes in both directions and over three divider values. A byte-order or fill error would put the bytes in the wrong lane of the receive word, or send the wrong transmit bytes, and a divider off by one would show up as a wrong high-phase width. Loop counts from zero to three check that the branched body runs exactly count-plus-one times; an off-by-one counter would clock one byte too many or too few. The stall cases (an empty transmit word, a full receive word, and the implicit dummy write) are observed as an absence of SCK edges, so an engine that failed to wait would visibly clock the slave. The overrun, underrun and two-step reset cases catch flags that are not sticky, status writes that also wipe the full flags, and a reset that fires on the second pattern alone or leaves a select asserted.

// File: rtl/spiseq_pkg.sv
// Shared constants and types for the SPI byte sequencer.
// Assumes a 64-bit register word and eight one-byte program slots.
package spiseq_pkg;
    localparam int WORD_W  = 64;
    localparam int IDX_W   = 4;

    // register indices
    localparam logic [IDX_W-1:0] IDX_LOOPCFG = 4'd1;
    localparam logic [IDX_W-1:0] IDX_CLKCFG  = 4'd3;
    localparam logic [IDX_W-1:0] IDX_TXD     = 4'd5;
    localparam logic [IDX_W-1:0] IDX_RXD     = 4'd6;
    localparam logic [IDX_W-1:0] IDX_PROG    = 4'd7;
    localparam logic [IDX_W-1:0] IDX_STAT    = 4'd8;

    // loop configuration fields
    localparam int LOOP_LSB = 32;
    localparam int LOOP_W   = 8;
    localparam int IMPL_BIT = 10;

    // clock configuration fields
    localparam int DIV_LSB  = 52;
    localparam int DIV_W    = 12;
    localparam int RST_A0   = 36;
    localparam int RST_A1   = 38;
    localparam int RST_B0   = 37;
    localparam int RST_B1   = 39;

    // status fields
    localparam int ST_RFULL = 63;
    localparam int ST_RUND  = 61;
    localparam int ST_TFULL = 59;
    localparam int ST_TOVR  = 58;
    localparam int ST_STATE = 48;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_FETCH = 2'd1,
        ENG_WAIT  = 2'd2,
        ENG_SHIFT = 2'd3
    } eng_state_t;

    typedef enum logic [1:0] {
        KIND_OUT  = 2'd0,
        KIND_IN   = 2'd1,
        KIND_COPY = 2'd2
    } op_kind_t;
endpackage

// File: rtl/spiseq_shifter.sv
// Mode-0 bit shifter: clocks 8*nbytes bits, MOSI from the top bit of the
// loaded word, MISO shifted into the bottom of the receive word on each
// rising SCK. Assumes start is only raised while idle and nbytes is 1..8.
module spiseq_shifter #(
    parameter int DATA_W = 64,
    parameter int DIV_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start,
    input  logic [3:0]        nbytes,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [DIV_W-1:0]  div,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [DIV_W-1:0]  phase_cnt;
    logic [CNT_W-1:0]  bits_left;
    logic [DATA_W-1:0] tx_sh;

    // bit timing, shifting and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            sck       <= 1'b0;
            phase_cnt <= '0;
            bits_left <= '0;
            tx_sh     <= '0;
            rx_word   <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy      <= 1'b1;
                sck       <= 1'b0;
                phase_cnt <= '0;
                bits_left <= CNT_W'({nbytes, 3'b000});
                tx_sh     <= tx_word;
                rx_word   <= '0;
            end else if (busy) begin
                if (phase_cnt == div) begin
                    phase_cnt <= '0;
                    if (!sck) begin
                        sck     <= 1'b1;
                        rx_word <= {rx_word[DATA_W-2:0], miso};
                    end else begin
                        sck       <= 1'b0;
                        tx_sh     <= {tx_sh[DATA_W-2:0], 1'b0};
                        bits_left <= bits_left - 1'b1;
                        if (bits_left == CNT_W'(1)) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end
                    end
                end else begin
                    phase_cnt <= phase_cnt + 1'b1;
                end
            end
        end
    end

    // MOSI is driven only while a byte is in flight
    always_comb mosi = busy & tx_sh[DATA_W-1];

    p_sck_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/spiseq_engine.sv
// Opcode engine: fetches one program byte per cycle, drives chip selects,
// hands shifts to the shifter and handles waits, copy and counted branch.
// Assumes prog is stable while running; start restarts from slot 0.
module spiseq_engine
    import spiseq_pkg::*;
#(
    parameter int NUM_CS  = 4,
    parameter int CNT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              soft_rst,
    input  logic [WORD_W-1:0] prog,
    input  logic [CNT_W-1:0]  loop_init,
    input  logic              implicit_en,
    input  logic              tdr_full,
    input  logic              rdr_full,
    input  logic              sh_done,
    output logic              sh_start,
    output logic [3:0]        sh_nbytes,
    output logic              take_tx,
    output logic              load_rx,
    output logic              copy_rx,
    output logic [NUM_CS-1:0] cs_n,
    output logic [3:0]        state_bits
);
    eng_state_t      state;
    op_kind_t        kind;
    logic [2:0]      pc;
    logic [CNT_W-1:0] loop_q;
    logic            armed;
    logic [3:0]      nbytes_q;
    logic [7:0]      op;
    logic            last_slot;
    logic            wait_go;
    logic [NUM_CS-1:0] sel_dec;

    // current opcode and end-of-program detection
    always_comb begin
        op        = prog[{~pc, 3'b000} +: 8];
        last_slot = (pc == 3'd7);
    end

    // chip-select decode of the low opcode nibble
    always_comb begin
        for (int i = 0; i < NUM_CS; i++) begin
            sel_dec[i] = (op[3:0] != 4'(i + 1));
        end
    end

    // wait release condition per operation kind
    always_comb begin
        unique case (kind)
            KIND_OUT:  wait_go = tdr_full;
            KIND_IN:   wait_go = !rdr_full && (!armed || tdr_full);
            KIND_COPY: wait_go = rdr_full && !tdr_full;
            default:   wait_go = 1'b0;
        endcase
    end

    // handshake strobes toward the shifter and the data registers
    always_comb begin
        sh_start   = (state == ENG_WAIT) && wait_go && (kind != KIND_COPY);
        take_tx    = sh_start && ((kind == KIND_OUT) || armed);
        copy_rx    = (state == ENG_WAIT) && wait_go && (kind == KIND_COPY);
        load_rx    = (state == ENG_SHIFT) && sh_done && (kind == KIND_IN);
        sh_nbytes  = nbytes_q;
        state_bits = 4'(1) << state;
    end

    // program counter, loop counter and state sequencing
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state    <= ENG_IDLE;
            kind     <= KIND_OUT;
            pc       <= '0;
            loop_q   <= '0;
            armed    <= 1'b0;
            nbytes_q <= 4'd1;
            cs_n     <= '1;
        end else if (start) begin
            state  <= ENG_FETCH;
            pc     <= '0;
            loop_q <= loop_init;
            armed  <= implicit_en;
        end else begin
            unique case (state)
                ENG_FETCH: begin
                    unique case (op[7:4])
                        4'h0: begin
                            if (op[3:0] == 4'h0) begin
                                state <= ENG_IDLE;
                            end else if (last_slot) begin
                                state <= ENG_IDLE;
                            end else begin
                                pc <= pc + 3'd1;
                            end
                        end
                        4'h1: begin
                            cs_n <= sel_dec;
                            if (last_slot) state <= ENG_IDLE;
                            else           pc <= pc + 3'd1;
                        end
                        4'h3, 4'h4: begin
                            if (op[3:0] == 4'h0) begin
                                if (last_slot) state <= ENG_IDLE;
                                else           pc <= pc + 3'd1;
                            end else begin
                                nbytes_q <= (op[3:0] > 4'd8) ? 4'd8 : op[3:0];
                                kind     <= (op[7:4] == 4'h3) ? KIND_OUT : KIND_IN;
                                state    <= ENG_WAIT;
                            end
                        end
                        4'hC: begin
                            if (op[3:0] == 4'h0) begin
                                kind  <= KIND_COPY;
                                state <= ENG_WAIT;
                            end else if (last_slot) begin
                                state <= ENG_IDLE;
                            end else begin
                                pc <= pc + 3'd1;
                            end
                        end
                        4'hE: begin
                            if (loop_q != '0) begin
                                loop_q <= loop_q - 1'b1;
                                pc     <= op[2:0];
                            end else if (last_slot) begin
                                state <= ENG_IDLE;
                            end else begin
                                pc <= pc + 3'd1;
                            end
                        end
                        default: begin
                            if (last_slot) state <= ENG_IDLE;
                            else           pc <= pc + 3'd1;
                        end
                    endcase
                end
                ENG_WAIT: begin
                    if (sh_start) begin
                        state <= ENG_SHIFT;
                        if (kind == KIND_IN) armed <= 1'b0;
                    end else if (copy_rx) begin
                        if (last_slot) state <= ENG_IDLE;
                        else begin
                            pc    <= pc + 3'd1;
                            state <= ENG_FETCH;
                        end
                    end
                end
                ENG_SHIFT: begin
                    if (sh_done) begin
                        if (last_slot) state <= ENG_IDLE;
                        else begin
                            pc    <= pc + 3'd1;
                            state <= ENG_FETCH;
                        end
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    p_rx_into_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_rx |-> !rdr_full);

    p_loop_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_FETCH && op[7:4] == 4'hE && loop_q != '0 && !start && !soft_rst)
        |=> (loop_q == $past(loop_q) - 1'b1) && (pc == $past(op[2:0])));

    p_idle_no_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_IDLE) |-> !sh_start && !copy_rx);
endmodule

// File: rtl/spi_byte_sequencer.sv
// Top of the SPI byte sequencer: register file, data-register handshake
// flags, status word and two-step soft reset, around the opcode engine and
// the bit shifter. Assumes at most one of reg_wr / reg_rd per cycle.
module spi_byte_sequencer
    import spiseq_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [IDX_W-1:0]     reg_idx,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic                 spi_sck,
    output logic                 spi_mosi,
    input  logic                 spi_miso,
    output logic [NUM_CS-1:0]    spi_cs_n
);
    logic [WORD_W-1:0] loopcfg_q, clkcfg_q, tx_q, rx_q, prog_q;
    logic tdr_full, rdr_full, tdr_ovr, rdr_und, rst_armed;
    logic wr_loop, wr_clk, wr_tx, wr_prog, wr_stat, rd_rx, soft_rst;
    logic sh_start, sh_done, sh_busy, take_tx, load_rx, copy_rx;
    logic [3:0] sh_nbytes, state_bits;
    logic [WORD_W-1:0] sh_rx, status_w;

    // register access decode and soft-reset detection
    always_comb begin
        wr_loop  = reg_wr && (reg_idx == IDX_LOOPCFG);
        wr_clk   = reg_wr && (reg_idx == IDX_CLKCFG);
        wr_tx    = reg_wr && (reg_idx == IDX_TXD);
        wr_prog  = reg_wr && (reg_idx == IDX_PROG);
        wr_stat  = reg_wr && (reg_idx == IDX_STAT);
        rd_rx    = reg_rd && (reg_idx == IDX_RXD);
        soft_rst = wr_clk && rst_armed && reg_wdata[RST_B0] && reg_wdata[RST_B1];
    end

    // configuration and program registers, reset arming
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loopcfg_q <= '0;
            clkcfg_q  <= '0;
            prog_q    <= '0;
            rst_armed <= 1'b0;
        end else begin
            if (wr_loop) loopcfg_q <= reg_wdata;
            if (wr_prog) prog_q    <= reg_wdata;
            if (wr_clk) begin
                clkcfg_q  <= reg_wdata;
                rst_armed <= reg_wdata[RST_A0] && reg_wdata[RST_A1];
            end
        end
    end

    // transmit word and its full / overrun flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q     <= '0;
            tdr_full <= 1'b0;
            tdr_ovr  <= 1'b0;
        end else if (soft_rst) begin
            tdr_full <= 1'b0;
            tdr_ovr  <= 1'b0;
        end else begin
            if (take_tx) tdr_full <= 1'b0;
            if (copy_rx) begin
                tx_q     <= rx_q;
                tdr_full <= 1'b1;
            end
            if (wr_tx) begin
                if (tdr_full) begin
                    tdr_ovr <= 1'b1;
                end else begin
                    tx_q     <= reg_wdata;
                    tdr_full <= 1'b1;
                end
            end
            if (wr_stat) tdr_ovr <= 1'b0;
        end
    end

    // receive word and its full / underrun flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q     <= '0;
            rdr_full <= 1'b0;
            rdr_und  <= 1'b0;
        end else if (soft_rst) begin
            rdr_full <= 1'b0;
            rdr_und  <= 1'b0;
        end else begin
            if (rd_rx) begin
                if (rdr_full) rdr_full <= 1'b0;
                else          rdr_und  <= 1'b1;
            end
            if (copy_rx) rdr_full <= 1'b0;
            if (load_rx) begin
                rx_q     <= sh_rx;
                rdr_full <= 1'b1;
            end
            if (wr_stat) rdr_und <= 1'b0;
        end
    end

    // status word assembly
    always_comb begin
        status_w              = '0;
        status_w[ST_RFULL]    = rdr_full;
        status_w[ST_RUND]     = rdr_und;
        status_w[ST_TFULL]    = tdr_full;
        status_w[ST_TOVR]     = tdr_ovr;
        status_w[ST_STATE+:4] = state_bits;
    end

    // read data multiplexer
    always_comb begin
        unique case (reg_idx)
            IDX_LOOPCFG: reg_rdata = loopcfg_q;
            IDX_CLKCFG:  reg_rdata = clkcfg_q;
            IDX_TXD:     reg_rdata = tx_q;
            IDX_RXD:     reg_rdata = rx_q;
            IDX_PROG:    reg_rdata = prog_q;
            IDX_STAT:    reg_rdata = status_w;
            default:     reg_rdata = '0;
        endcase
    end

    spiseq_engine #(
        .NUM_CS (NUM_CS),
        .CNT_W  (LOOP_W)
    ) engine_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (wr_prog),
        .soft_rst    (soft_rst),
        .prog        (wr_prog ? reg_wdata : prog_q),
        .loop_init   (loopcfg_q[LOOP_LSB +: LOOP_W]),
        .implicit_en (loopcfg_q[IMPL_BIT]),
        .tdr_full    (tdr_full),
        .rdr_full    (rdr_full),
        .sh_done     (sh_done),
        .sh_start    (sh_start),
        .sh_nbytes   (sh_nbytes),
        .take_tx     (take_tx),
        .load_rx     (load_rx),
        .copy_rx     (copy_rx),
        .cs_n        (spi_cs_n),
        .state_bits  (state_bits)
    );

    spiseq_shifter #(
        .DATA_W (WORD_W),
        .DIV_W  (DIV_W)
    ) shifter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort   (wr_prog || soft_rst),
        .start   (sh_start),
        .nbytes  (sh_nbytes),
        .tx_word (tx_q),
        .div     (clkcfg_q[DIV_LSB +: DIV_W]),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .busy    (sh_busy),
        .done    (sh_done),
        .rx_word (sh_rx)
    );

    p_take_needs_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_tx |-> tdr_full);

    p_tx_write_sets_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && !tdr_full) |=> tdr_full);

    p_rx_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && rdr_full) |=> !rdr_full);

    p_start_idle_shifter_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |-> !sh_busy);

    p_soft_reset_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !tdr_full && !rdr_full && (&spi_cs_n) && !spi_sck);
endmodule

// File: tb/spi_byte_sequencer_tb.sv
module spi_byte_sequencer_tb_top;
    localparam int NCS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_idx = 4'd0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        spi_sck, spi_mosi, spi_miso;
    logic [NCS-1:0] spi_cs_n;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    spi_byte_sequencer #(.NUM_CS(NCS)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    // slave stream byte k
    function automatic logic [7:0] sb(input int k);
        return 8'(k * 29 + 7) ^ 8'h5A;
    endfunction

    // slave model: MISO from the stream, MOSI captured on rising SCK
    int sptr = 0;
    int mcnt = 0;
    logic [7:0] mshift = '0;
    logic [7:0] mbytes [64];
    assign spi_miso = sb(sptr / 8)[7 - (sptr % 8)];
    always @(posedge spi_sck) begin
        mshift = {mshift[6:0], spi_mosi};
        mcnt = mcnt + 1;
        if (mcnt % 8 == 0) mbytes[((mcnt / 8) - 1) % 64] = mshift;
    end
    always @(negedge spi_sck) sptr = sptr + 1;

    // high-phase width in clock cycles
    int hcnt = 0;
    int last_high = 0;
    always @(negedge clk) begin
        if (spi_sck) hcnt = hcnt + 1;
        else begin
            if (hcnt != 0) last_high = hcnt;
            hcnt = 0;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [63:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_idx = idx;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        logic [63:0] s;
        s = '0;
        for (int i = 0; i < 3000; i++) begin
            rd(4'd8, s);
            if (s[48]) break;
        end
        check({req, " idle reached"}, 64'(s[48]), 64'd1);
    endtask

    task automatic wait_tdr_empty();
        logic [63:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(4'd8, s);
            if (!s[59]) break;
        end
    endtask

    task automatic clr_slave();
        sptr = 0; mcnt = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] s, exp, w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd8, s);
        check("R1 status after reset", s, 64'h0001_0000_0000_0000);
        check("R1 chip selects", 64'(spi_cs_n), 64'hF);
        check("R1 sck low", 64'(spi_sck), 64'd0);
        rd(4'd6, s);
        check("R1 rx word zero", s, 64'd0);
        // clear the underrun that read caused
        wr(4'd8, 64'd0);

        // R2 select decode sweep
        for (int n = 0; n < 6; n++) begin
            wr(4'd7, {8'(8'h10 + n), 56'h0});
            wait_idle("R2");
            exp = 64'hF;
            if (n >= 1 && n <= NCS) exp[n-1] = 1'b0;
            check($sformatf("R2 select %0d", n), 64'(spi_cs_n), exp);
        end

        // R3 / R10 shift-out sweep over divider and length
        for (int d = 0; d < 3; d++) begin
            wr(4'd3, 64'(d) << 52);
            for (int n = 1; n <= 8; n++) begin
                clr_slave();
                w = '0;
                for (int i = 0; i < 8; i++) w = (w << 8) | 64'(sb(3 * n + i + 11 * d));
                wr(4'd5, w);
                rd(4'd8, s);
                check("R3 tx write sets full", 64'(s[59]), 64'd1);
                wr(4'd7, {8'h11, 8'(8'h30 + n), 8'h10, 40'h0});
                wait_idle("R3");
                check($sformatf("R3 bit count n=%0d", n), 64'(mcnt), 64'(8 * n));
                for (int i = 0; i < n; i++)
                    check($sformatf("R3 byte %0d of %0d", i, n), 64'(mbytes[i]), 64'(w[63 - 8 * i -: 8]));
                rd(4'd8, s);
                check("R3 full cleared", 64'(s[59]), 64'd0);
                check($sformatf("R10 high width div=%0d", d), 64'(last_high), 64'(d + 1));
                check("R10 sck idle low", 64'(spi_sck), 64'd0);
            end
        end
        wr(4'd3, 64'd0);

        // R3 stall on empty transmit word
        clr_slave();
        wr(4'd7, {8'h11, 8'h31, 8'h10, 40'h0});
        repeat (40) @(negedge clk);
        check("R3 no sck while tx empty", 64'(mcnt), 64'd0);
        wr(4'd5, {8'hA5, 56'h0});
        wait_idle("R3");
        check("R3 byte after stall", 64'(mbytes[0]), 64'hA5);

        // R4 shift-in sweep
        for (int n = 1; n <= 8; n++) begin
            clr_slave();
            wr(4'd7, {8'h12, 8'(8'h40 + n), 8'h10, 40'h0});
            wait_idle("R4");
            rd(4'd8, s);
            check("R4 rx full set", 64'(s[63]), 64'd1);
            exp = '0;
            for (int i = 0; i < n; i++) exp = (exp << 8) | 64'(sb(i));
            rd(4'd6, s);
            check($sformatf("R4 rx word n=%0d", n), s, exp);
            rd(4'd8, s);
            check("R4 read clears full", 64'(s[63]), 64'd0);
        end

        // R5 stall while receive word full
        clr_slave();
        wr(4'd7, {8'h11, 8'h41, 8'h41, 8'h10, 32'h0});
        repeat (120) @(negedge clk);
        check("R5 only one byte clocked", 64'(sptr), 64'd8);
        rd(4'd8, s);
        check("R5 engine not idle", 64'(s[48]), 64'd0);
        rd(4'd6, s);
        check("R5 first byte", s, 64'(sb(0)));
        wait_idle("R5");
        rd(4'd6, s);
        check("R5 second byte", s, 64'(sb(1)));

        // R6 counted branch
        for (int l = 0; l < 4; l++) begin
            clr_slave();
            wr(4'd1, 64'(l) << 32);
            wr(4'd7, {8'h11, 8'h31, 8'hE1, 8'h10, 32'h0});
            for (int k = 0; k <= l; k++) begin
                wait_tdr_empty();
                wr(4'd5, {sb(50 + k), 56'h0});
            end
            wait_idle("R6");
            check($sformatf("R6 bits for loop %0d", l), 64'(mcnt), 64'(8 * (l + 1)));
            for (int k = 0; k <= l; k++)
                check($sformatf("R6 byte %0d loop %0d", k, l), 64'(mbytes[k]), 64'(sb(50 + k)));
        end

        // R7 implicit start of receive
        clr_slave();
        wr(4'd1, 64'd1 << 10);
        wr(4'd7, {8'h11, 8'h42, 8'h10, 40'h0});
        repeat (60) @(negedge clk);
        check("R7 no sck before dummy write", 64'(sptr), 64'd0);
        wr(4'd5, 64'd0);
        wait_idle("R7");
        rd(4'd6, s);
        check("R7 rx data", s, {48'h0, sb(0), sb(1)});
        rd(4'd8, s);
        check("R7 dummy consumed", 64'(s[59]), 64'd0);
        wr(4'd1, 64'd0);

        // R8 copy receive into transmit and echo
        clr_slave();
        wr(4'd7, {8'h11, 8'h48, 8'hC0, 8'h38, 8'h10, 24'h0});
        wait_idle("R8");
        check("R8 total bits", 64'(mcnt), 64'd128);
        for (int i = 0; i < 8; i++)
            check($sformatf("R8 echo byte %0d", i), 64'(mbytes[8 + i]), 64'(sb(i)));
        rd(4'd8, s);
        check("R8 flags after copy", {s[63], s[59]}, 64'd0);

        // R9 stop, unknown opcode, end of program
        wr(4'd7, {8'h11, 8'h00, 8'h12, 40'h0});
        wait_idle("R9");
        check("R9 stop keeps select", 64'(spi_cs_n), 64'hE);
        wr(4'd7, {8'h12, 8'h77, 8'h11, 40'h0});
        wait_idle("R9");
        check("R9 unknown skipped", 64'(spi_cs_n), 64'hE);
        wr(4'd7, 64'h10_11_10_11_10_11_10_12);
        wait_idle("R9");
        check("R9 all eight slots run", 64'(spi_cs_n), 64'hD);

        // R11 overrun, underrun, status clear
        wr(4'd5, 64'h1111_2222_3333_4444);
        wr(4'd5, 64'h5555_6666_7777_8888);
        rd(4'd5, s);
        check("R11 second write dropped", s, 64'h1111_2222_3333_4444);
        rd(4'd6, s);
        rd(4'd8, s);
        check("R11 error flags", {s[62:61], s[58:57]}, 64'b0110);
        wr(4'd8, 64'd0);
        rd(4'd8, s);
        check("R11 status write clears errors only", s[63:56], 64'h08);

        // R12 two-step soft reset while stalled
        wr(4'd7, {8'h12, 8'h31, 8'h31, 40'h0});
        repeat (60) @(negedge clk);
        check("R12 select before reset", 64'(spi_cs_n), 64'hD);
        wr(4'd3, (64'd1 << 37) | (64'd1 << 39));
        rd(4'd8, s);
        check("R12 second pattern alone ignored", 64'(s[48]), 64'd0);
        wr(4'd3, (64'd1 << 36) | (64'd1 << 38));
        wr(4'd3, (64'd1 << 37) | (64'd1 << 39));
        rd(4'd8, s);
        check("R12 status after reset", s, 64'h0001_0000_0000_0000);
        check("R12 selects released", 64'(spi_cs_n), 64'hF);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule